// File: doc/BRIEF.md
# Stack Address Sequencer

This block turns stack requests into memory requests and stack pointer updates. A single push moves the pointer down by the operand size (2 or 4 bytes) and writes at the segment base plus the moved pointer. A single pop reads at the segment base plus the current pointer and moves the pointer up by the operand size. The pointer width is set per request by a mode bit and does not depend on the operand size. In narrow mode only the low 16 bits of the pointer take part in the arithmetic and wrap, and the upper bits are kept. In wide mode the whole pointer is used.

A save-all request stores eight registers below the pointer. Before any write, the block asks a checker whether the whole region is writable. If the answer is negative, the request ends with an abort pulse and nothing is written. If the answer is positive, the block writes one register per cycle in a fixed order. In the fifth slot it writes the pointer value it sampled when the request was taken. While the sequence runs the block refuses all requests. It signals completion once the last write is done.

Top module: `stk_addr_seq`

## Requirements
- R1: After reset `ready` is 1 and `mem_wr`, `mem_rd`, `sp_we`, `chk_req`, `seq_done` and `seq_abort` are all 0.
- R2: A push taken in cycle t drives, in cycle t+1, a one-cycle `mem_wr` with `sp_we`. `sp_out` is the pointer minus the operand size (4 when `op32`=1, else 2). `mem_addr` is `ss_base` plus the moved pointer. `mem_size` gives the byte count.
- R3: A pop taken in cycle t drives, in cycle t+1, a one-cycle `mem_rd` with `sp_we`. `mem_addr` is `ss_base` plus the current pointer and `sp_out` is the pointer plus the operand size.
- R4: With `wide_stack`=0, the arithmetic uses bits 15:0 only and wraps modulo 65536. `sp_out[31:16]` equals `sp_in[31:16]` and the address offset is the 16-bit value zero-extended. A 4-byte operand still moves the pointer by 4.
- R5: With `wide_stack`=1, the full 32-bit pointer is used and carries or borrows cross bit 16.
- R6: A save-all request raises `chk_req` in the next cycle and holds it until `chk_done`. The request has `chk_addr` = `ss_base` + masked(pointer − 8×size) and `chk_len` = 8×size. No write happens while `chk_req` is high.
- R7: If `chk_done`=1 with `chk_ok`=0, `seq_abort` pulses for one cycle in the next cycle. No write and no pointer update happen, and `ready` returns to 1.
- R8: After a positive check, eight writes follow in eight consecutive cycles. The slots are 0..7 of `gpr_flat` (slot k in bits 32k+31:32k). Slot 4 is replaced by the pointer sampled at request time. Each write moves the pointer down by the operand size and carries it on `sp_out`.
- R9: `seq_done` pulses in the cycle after the eighth write, with `ready`=1. The last `sp_out` equals the sampled pointer minus 8×size under the R4 or R5 masking.
- R10: While `ready`=0, push, pop and save-all requests are ignored and produce no memory request. `mem_wr` and `mem_rd` are never both high.
- R11: When several requests arrive in one cycle, save-all wins over push, and push wins over pop.
- R12: For a 2-byte operand `mem_size` is 2 and `mem_wdata[31:16]` is 0. For a 4-byte operand `mem_size` is 4 and all 32 bits are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_base | input | 32 | Stack segment base address |
| sp_in | input | 32 | Current stack pointer |
| wide_stack | input | 1 | 1: 32-bit pointer arithmetic, 0: 16-bit wrap |
| op32 | input | 1 | 1: 4-byte operand, 0: 2-byte operand |
| push_req | input | 1 | Single push request |
| pop_req | input | 1 | Single pop request |
| pusha_req | input | 1 | Save-all-registers request |
| push_data | input | 32 | Value for a single push |
| gpr_flat | input | 256 | Eight register values for save-all, slot 0 lowest |
| chk_done | input | 1 | Region check answer valid |
| chk_ok | input | 1 | Region is writable |
| ready | output | 1 | Block accepts requests |
| chk_req | output | 1 | Region check request |
| chk_addr | output | 32 | Lowest address of the region |
| chk_len | output | 32 | Region length in bytes |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_size | output | 3 | Access size in bytes (2 or 4) |
| sp_we | output | 1 | Pointer update strobe |
| sp_out | output | 32 | Updated stack pointer |
| seq_done | output | 1 | Save-all finished |
| seq_abort | output | 1 | Save-all refused by the check |

## Verification
The bench builds the block with its default values: a 32-bit pointer and data path and eight register slots, with the saved pointer in slot 4. These widths let the bench check both R4 and R5. Pointers near 0x0000 and 0xFFFF show a 16-bit wrap in narrow mode and a borrow or carry into bit 16 in wide mode. Eight slots give a sequence long enough for the wrap to occur in the middle of a save-all. With slot 4 at the default position, the bench can see the sampled pointer written even after `sp_in` has changed during the sequence.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CHECK = 2'd1,
    SQ_WRITE = 2'd2,
    SQ_FIN   = 2'd3
  } sq_state_e;
endpackage

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] sp,
  input  logic [PW-1:0] delta,
  input  logic          wide,
  input  logic          down,
  input  logic          use_new,
  output logic [PW-1:0] nxt_sp,
  output logic [PW-1:0] addr
);
  localparam int HW = stk_pkg::HALF_W;
  localparam int UW = PW - HW;

  logic [PW-1:0] moved;
  logic [PW-1:0] pick;
  logic [PW-1:0] offset;

  always_comb begin
    moved  = down ? (sp - delta) : (sp + delta);
    nxt_sp = wide ? moved : {sp[PW-1:HW], moved[HW-1:0]};
    pick   = use_new ? moved : sp;
    offset = wide ? pick : {{UW{1'b0}}, pick[HW-1:0]};
    addr   = base + offset;
  end
endmodule

// File: rtl/stk_pusha_seq.sv
module stk_pusha_seq #(
  parameter int PW      = 32,
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int SP_SLOT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PW-1:0]      ss_base,
  input  logic [PW-1:0]      sp_in,
  input  logic               wide,
  input  logic               op32,
  input  logic [NREG*DW-1:0] regs_flat,
  input  logic               chk_done,
  input  logic               chk_ok,
  output logic               busy,
  output logic               chk_req,
  output logic [PW-1:0]      chk_addr,
  output logic [PW-1:0]      chk_len,
  output logic               wr_en,
  output logic [PW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  output logic [PW-1:0]      wr_sp,
  output logic [2:0]         wr_bytes,
  output logic               done,
  output logic               abort
);
  import stk_pkg::*;
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int HW = HALF_W;

  sq_state_e state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [PW-1:0] cur_sp_q, cur_sp_n;
  logic [PW-1:0] orig_sp_q, base_q, end_sp_q;
  logic          wide_q, op32_q;
  logic [DW-1:0] regs_q [NREG];
  logic          cap_en;

  logic          chk_req_q, chk_req_n;
  logic [PW-1:0] chk_addr_q, chk_addr_n, chk_len_q, chk_len_n;
  logic          wr_en_q, wr_en_n;
  logic [PW-1:0] wr_addr_q, wr_addr_n, wr_sp_q, wr_sp_n;
  logic [DW-1:0] wr_data_q, wr_data_n;
  logic          done_q, done_n, abort_q, abort_n;

  logic [PW-1:0] step_in, step_q, region;
  logic [PW-1:0] rgn_low_sp, rgn_addr, seq_sp, seq_addr;
  logic [DW-1:0] pick;

  assign step_in = op32 ? PW'(4) : PW'(2);
  assign step_q  = op32_q ? PW'(4) : PW'(2);
  assign region  = step_in * PW'(NREG);
  assign cap_en  = (state_q == SQ_IDLE) && start;

  stk_ptr_unit #(.PW(PW)) u_rgn (
    .base(ss_base), .sp(sp_in), .delta(region), .wide(wide),
    .down(1'b1), .use_new(1'b1), .nxt_sp(rgn_low_sp), .addr(rgn_addr)
  );

  stk_ptr_unit #(.PW(PW)) u_step (
    .base(base_q), .sp(cur_sp_q), .delta(step_q), .wide(wide_q),
    .down(1'b1), .use_new(1'b1), .nxt_sp(seq_sp), .addr(seq_addr)
  );

  always_comb begin
    pick = (idx_q == IW'(SP_SLOT)) ? DW'(orig_sp_q) : regs_q[idx_q];
    if (!op32_q) pick = {{(DW-HW){1'b0}}, pick[HW-1:0]};
  end

  always_comb begin
    state_n    = state_q;
    idx_n      = idx_q;
    cur_sp_n   = cur_sp_q;
    chk_req_n  = 1'b0;
    chk_addr_n = chk_addr_q;
    chk_len_n  = chk_len_q;
    wr_en_n    = 1'b0;
    wr_addr_n  = wr_addr_q;
    wr_data_n  = wr_data_q;
    wr_sp_n    = wr_sp_q;
    done_n     = 1'b0;
    abort_n    = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        state_n    = SQ_CHECK;
        chk_req_n  = 1'b1;
        chk_addr_n = rgn_addr;
        chk_len_n  = region;
        cur_sp_n   = sp_in;
        idx_n      = '0;
      end
      SQ_CHECK: begin
        chk_req_n = 1'b1;
        if (chk_done) begin
          chk_req_n = 1'b0;
          if (chk_ok) state_n = SQ_WRITE;
          else begin
            state_n = SQ_IDLE;
            abort_n = 1'b1;
          end
        end
      end
      SQ_WRITE: begin
        wr_en_n   = 1'b1;
        wr_addr_n = seq_addr;
        wr_sp_n   = seq_sp;
        wr_data_n = pick;
        cur_sp_n  = seq_sp;
        idx_n     = idx_q + IW'(1);
        if (idx_q == IW'(NREG-1)) state_n = SQ_FIN;
      end
      SQ_FIN: begin
        done_n  = 1'b1;
        state_n = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      idx_q      <= '0;
      cur_sp_q   <= '0;
      chk_req_q  <= 1'b0;
      chk_addr_q <= '0;
      chk_len_q  <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wr_sp_q    <= '0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      state_q    <= state_n;
      idx_q      <= idx_n;
      cur_sp_q   <= cur_sp_n;
      chk_req_q  <= chk_req_n;
      chk_addr_q <= chk_addr_n;
      chk_len_q  <= chk_len_n;
      wr_en_q    <= wr_en_n;
      wr_addr_q  <= wr_addr_n;
      wr_data_q  <= wr_data_n;
      wr_sp_q    <= wr_sp_n;
      done_q     <= done_n;
      abort_q    <= abort_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_sp_q <= '0;
      base_q    <= '0;
      end_sp_q  <= '0;
      wide_q    <= 1'b0;
      op32_q    <= 1'b0;
    end else if (cap_en) begin
      orig_sp_q <= sp_in;
      base_q    <= ss_base;
      end_sp_q  <= rgn_low_sp;
      wide_q    <= wide;
      op32_q    <= op32;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[g] <= '0;
      else if (cap_en) regs_q[g] <= regs_flat[g*DW +: DW];
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign chk_req  = chk_req_q;
  assign chk_addr = chk_addr_q;
  assign chk_len  = chk_len_q;
  assign wr_en    = wr_en_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;
  assign wr_sp    = wr_sp_q;
  assign wr_bytes = op32_q ? 3'd4 : 3'd2;
  assign done     = done_q;
  assign abort    = abort_q;

  // R6
  chk_excl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req_q |-> !wr_en_q);
  // R7
  abort_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (!wr_en_q && !chk_req_q));
  // R8
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_q && $past(wr_en_q)) |->
      (wr_sp_q[HW-1:0] == 16'($past(wr_sp_q[HW-1:0]) - 16'(wr_bytes))));
  // R9
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(wr_en_q) && $past(wr_sp_q) == end_sp_q));
endmodule

// File: rtl/stk_addr_seq.sv
module stk_addr_seq #(
  parameter int PW      = 32,
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int SP_SLOT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PW-1:0]      ss_base,
  input  logic [PW-1:0]      sp_in,
  input  logic               wide_stack,
  input  logic               op32,
  input  logic               push_req,
  input  logic               pop_req,
  input  logic               pusha_req,
  input  logic [DW-1:0]      push_data,
  input  logic [NREG*DW-1:0] gpr_flat,
  input  logic               chk_done,
  input  logic               chk_ok,
  output logic               ready,
  output logic               chk_req,
  output logic [PW-1:0]      chk_addr,
  output logic [PW-1:0]      chk_len,
  output logic               mem_wr,
  output logic               mem_rd,
  output logic [PW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [2:0]         mem_size,
  output logic               sp_we,
  output logic [PW-1:0]      sp_out,
  output logic               seq_done,
  output logic               seq_abort
);
  localparam int HW = stk_pkg::HALF_W;

  logic busy;
  logic acc_pusha, acc_push, acc_pop, sg_en;
  logic [PW-1:0] step, sg_sp_n, sg_addr_n;
  logic [DW-1:0] sg_data_n;

  logic          sg_wr_q, sg_rd_q;
  logic [PW-1:0] sg_addr_q, sg_sp_q;
  logic [DW-1:0] sg_data_q;
  logic [2:0]    sg_size_q;

  logic          sq_wr;
  logic [PW-1:0] sq_addr, sq_sp;
  logic [DW-1:0] sq_data;
  logic [2:0]    sq_bytes;

  assign ready     = !busy;
  assign acc_pusha = ready && pusha_req;
  assign acc_push  = ready && push_req && !pusha_req;
  assign acc_pop   = ready && pop_req && !pusha_req && !push_req;
  assign sg_en     = acc_push || acc_pop;
  assign step      = op32 ? PW'(4) : PW'(2);
  assign sg_data_n = op32 ? push_data : {{(DW-HW){1'b0}}, push_data[HW-1:0]};

  stk_ptr_unit #(.PW(PW)) u_single (
    .base(ss_base), .sp(sp_in), .delta(step), .wide(wide_stack),
    .down(!acc_pop), .use_new(!acc_pop), .nxt_sp(sg_sp_n), .addr(sg_addr_n)
  );

  stk_pusha_seq #(.PW(PW), .DW(DW), .NREG(NREG), .SP_SLOT(SP_SLOT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(acc_pusha), .ss_base(ss_base),
    .sp_in(sp_in), .wide(wide_stack), .op32(op32), .regs_flat(gpr_flat),
    .chk_done(chk_done), .chk_ok(chk_ok), .busy(busy), .chk_req(chk_req),
    .chk_addr(chk_addr), .chk_len(chk_len), .wr_en(sq_wr), .wr_addr(sq_addr),
    .wr_data(sq_data), .wr_sp(sq_sp), .wr_bytes(sq_bytes),
    .done(seq_done), .abort(seq_abort)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_wr_q <= 1'b0;
      sg_rd_q <= 1'b0;
    end else begin
      sg_wr_q <= acc_push;
      sg_rd_q <= acc_pop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_addr_q <= '0;
      sg_sp_q   <= '0;
      sg_data_q <= '0;
      sg_size_q <= '0;
    end else if (sg_en) begin
      sg_addr_q <= sg_addr_n;
      sg_sp_q   <= sg_sp_n;
      sg_data_q <= acc_push ? sg_data_n : '0;
      sg_size_q <= op32 ? 3'd4 : 3'd2;
    end
  end

  assign mem_wr    = sg_wr_q || sq_wr;
  assign mem_rd    = sg_rd_q;
  assign mem_addr  = sq_wr ? sq_addr  : sg_addr_q;
  assign mem_wdata = sq_wr ? sq_data  : sg_data_q;
  assign mem_size  = sq_wr ? sq_bytes : sg_size_q;
  assign sp_we     = sg_wr_q || sg_rd_q || sq_wr;
  assign sp_out    = sq_wr ? sq_sp    : sg_sp_q;

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));
  // R10
  busy_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !mem_rd);
  // R12
  half_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_size == 3'd2) |-> (mem_wdata[DW-1:HW] == '0));
endmodule

// File: tb/test_stk_addr_seq.sv
module test_stk_addr_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] ss_base, sp_in, push_data;
  logic wide_stack, op32, push_req, pop_req, pusha_req, chk_done, chk_ok;
  logic [255:0] gpr_flat;
  logic ready, chk_req, mem_wr, mem_rd, sp_we, seq_done, seq_abort;
  logic [31:0] chk_addr, chk_len, mem_addr, mem_wdata, sp_out;
  logic [2:0] mem_size;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  stk_addr_seq i_stk_addr_seq (
    .clk(clk), .rst_n(rst_n), .ss_base(ss_base), .sp_in(sp_in),
    .wide_stack(wide_stack), .op32(op32), .push_req(push_req),
    .pop_req(pop_req), .pusha_req(pusha_req), .push_data(push_data),
    .gpr_flat(gpr_flat), .chk_done(chk_done), .chk_ok(chk_ok),
    .ready(ready), .chk_req(chk_req), .chk_addr(chk_addr), .chk_len(chk_len),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .sp_we(sp_we),
    .sp_out(sp_out), .seq_done(seq_done), .seq_abort(seq_abort)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] regval(int k);
    return 32'hC0DE_0000 + 32'(k) * 32'h0001_0111;
  endfunction

  function automatic logic [31:0] moved(logic [31:0] sp, int d, logic wide);
    logic [31:0] m = sp + 32'(d);
    return wide ? m : {sp[31:16], m[15:0]};
  endfunction

  function automatic logic [31:0] offs(logic [31:0] p, logic wide);
    return wide ? p : {16'h0, p[15:0]};
  endfunction

  task automatic t_reset();
    check("R1", "ready", 32'(ready), 1);
    check("R1", "strobes", {26'h0, mem_wr, mem_rd, sp_we, chk_req, seq_done, seq_abort}, 0);
  endtask

  // single push or pop; kind 1 = push, 0 = pop
  task automatic t_single(string req, bit kind, logic wide, logic w4,
                          logic [31:0] base, logic [31:0] sp, logic [31:0] data);
    int b = w4 ? 4 : 2;
    logic [31:0] nsp = moved(sp, kind ? -b : b, wide);
    logic [31:0] ea  = base + offs(kind ? nsp : sp, wide);
    logic [31:0] ed  = w4 ? data : {16'h0, data[15:0]};
    @(negedge clk);
    wide_stack = wide; op32 = w4; ss_base = base; sp_in = sp; push_data = data;
    push_req = kind; pop_req = !kind;
    @(posedge clk); #1;
    check(req, "wr", 32'(mem_wr), 32'(kind));
    check(req, "rd", 32'(mem_rd), 32'(!kind));
    check(req, "sp_we", 32'(sp_we), 1);
    check(req, "addr", mem_addr, ea);
    check(req, "sp_out", sp_out, nsp);
    check(req, "size", 32'(mem_size), 32'(b));
    if (kind) check(req, "wdata", mem_wdata, ed);
    @(negedge clk);
    push_req = 0; pop_req = 0;
    @(posedge clk); #1;
    check(req, "one cycle", 32'(mem_wr | mem_rd | sp_we), 0);
  endtask

  // R11: simultaneous push and pop
  task automatic t_prio();
    @(negedge clk);
    wide_stack = 1; op32 = 1; ss_base = 32'h100; sp_in = 32'h80;
    push_data = 32'h1234_5678; push_req = 1; pop_req = 1;
    @(posedge clk); #1;
    check("R11", "push wins wr", 32'(mem_wr), 1);
    check("R11", "push wins rd", 32'(mem_rd), 0);
    check("R11", "push addr", mem_addr, 32'h17C);
    @(negedge clk);
    push_req = 0; pop_req = 0;
  endtask

  // save-all sequence; ok selects the check answer, also_push tests R11 at start
  task automatic t_pusha(string req, logic wide, logic w4, logic [31:0] base,
                         logic [31:0] sp, bit ok, bit also_push);
    int b = w4 ? 4 : 2;
    @(negedge clk);
    wide_stack = wide; op32 = w4; ss_base = base; sp_in = sp;
    pusha_req = 1; push_req = also_push; pop_req = also_push;
    @(posedge clk); #1;
    check("R6", "chk_req", 32'(chk_req), 1);
    check("R6", "chk_addr", chk_addr, base + offs(moved(sp, -8*b, wide), wide));
    check("R6", "chk_len", chk_len, 32'(8*b));
    check("R11", "no single op at start", 32'(mem_wr | mem_rd), 0);
    check("R10", "ready low", 32'(ready), 0);
    @(negedge clk);
    pusha_req = 0; push_req = 1; pop_req = 0; sp_in = 32'h5A5A_5A5A;
    @(posedge clk); #1;
    check("R6", "chk_req held", 32'(chk_req), 1);
    check("R10", "push ignored", 32'(mem_wr | sp_we), 0);
    @(negedge clk);
    chk_done = 1; chk_ok = ok;
    @(posedge clk); #1;
    check(req, "chk_req drop", 32'(chk_req), 0);
    check(req, "no write yet", 32'(mem_wr | sp_we), 0);
    if (!ok) begin
      check("R7", "abort", 32'(seq_abort), 1);
      check("R7", "ready back", 32'(ready), 1);
      @(negedge clk);
      chk_done = 0; push_req = 0;
      @(posedge clk); #1;
      check("R7", "abort one cycle", 32'(seq_abort), 0);
      check("R7", "no write after abort", 32'(mem_wr | sp_we), 0);
    end else begin
      @(negedge clk);
      chk_done = 0;
      for (int k = 0; k < 8; k++) begin
        logic [31:0] esp = moved(sp, -(k+1)*b, wide);
        logic [31:0] raw = (k == 4) ? sp : regval(k);
        @(posedge clk); #1;
        check("R8", $sformatf("wr %0d", k), 32'(mem_wr), 1);
        check("R8", $sformatf("addr %0d", k), mem_addr, base + offs(esp, wide));
        check("R8", $sformatf("sp %0d", k), sp_out, esp);
        check("R12", $sformatf("data %0d", k), mem_wdata, w4 ? raw : {16'h0, raw[15:0]});
        check("R12", $sformatf("size %0d", k), 32'(mem_size), 32'(b));
        check("R10", "busy", 32'(ready), 0);
      end
      check("R9", "final sp", sp_out, moved(sp, -8*b, wide));
      check("R9", "no done with last write", 32'(seq_done), 0);
      @(posedge clk); #1;
      check("R9", "done", 32'(seq_done), 1);
      check("R9", "ready at done", 32'(ready), 1);
      check("R10", "held push ignored", 32'(mem_wr | sp_we), 0);
      @(negedge clk);
      push_req = 0;
      @(posedge clk); #1;
      check("R9", "done one cycle", 32'(seq_done), 0);
      check("R10", "quiet", 32'(mem_wr | mem_rd), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; ss_base = 0; sp_in = 0; push_data = 0; wide_stack = 0; op32 = 0;
    push_req = 0; pop_req = 0; pusha_req = 0; chk_done = 0; chk_ok = 0;
    for (int k = 0; k < 8; k++) gpr_flat[k*32 +: 32] = regval(k);
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 t_reset();

    t_single("R2", 1, 1, 1, 32'h0002_0000, 32'h0000_1000, 32'hDEAD_BEEF);
    t_single("R12", 1, 1, 0, 32'h0002_0000, 32'h0000_1000, 32'hDEAD_BEEF);
    t_single("R4", 1, 0, 0, 32'h0003_0000, 32'h1234_0000, 32'hCAFE_F00D);
    t_single("R4", 1, 0, 1, 32'h0003_0000, 32'h0000_0002, 32'h0BAD_CAFE);
    t_single("R3", 0, 1, 1, 32'h0002_0000, 32'h0000_0FFC, 32'h0);
    t_single("R4", 0, 0, 0, 32'h0004_0000, 32'h5555_FFFE, 32'h0);
    t_single("R5", 1, 1, 0, 32'h0, 32'h0001_0000, 32'h0000_7777);
    t_single("R5", 0, 1, 1, 32'h0, 32'h0000_FFFE, 32'h0);
    t_prio();

    t_pusha("R8", 1, 1, 32'h1000_0000, 32'h0000_0100, 1, 0);
    t_pusha("R4", 0, 0, 32'h0800_0000, 32'hABCD_0008, 1, 1);
    t_pusha("R7", 1, 1, 32'h1000_0000, 32'h0000_0200, 0, 1);
    t_single("R2", 1, 1, 1, 32'h0, 32'h0000_0040, 32'h0101_0101);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule